// File: doc/BRIEF.md
# Interrupt Gate Dispatch Classifier

This block decides how a processor core enters an interrupt or exception handler. It works out whether the entry is a real-mode vector or a task-gate switch. It also recognises a same-level handler call, an entry through a privilege change, or an escape out of virtual-8086 mode. If any entry check fails, it reports which fault to raise and the 16-bit error code to push.

Upstream logic presents the machine state: protection enable, the virtual-8086 bit, the I/O privilege level and the current privilege level. Upstream logic also supplies facts about the event: whether it came from a software interrupt instruction, whether it is the one-byte breakpoint form, and whether it is external. Last, it supplies the vector, the descriptor table limit and fields already decoded from the gate and from the target code segment descriptor. The block fetches no memory of its own.

The inputs are sampled on a clock edge when `req_valid` is high. The verdict appears on the outputs one cycle later, and it is held until the next request. The checks run in a fixed priority order, and only the first failure is reported.

Top module: `intgate_classify`

## Requirements
- R1: A request sampled with `req_valid` high produces `out_valid` high on the next cycle. A cycle without a request produces `out_valid` low on the next cycle. After reset, `out_valid` is 0, `out_class` is 0 and `err_code` is 0.
- R2: The class codes on `out_class` are 0 real, 1 task, 2 intra, 3 inter, 4 v86, 5 general protection fault (GP) and 6 not-present fault (NP). Every dispatch class (0 to 4) reports `err_code` 0.
- R3: With `pe`=0, the class is real (0). If vector*4+3 exceeds `idt_limit`, the class is GP with error code 0 instead.
- R4: With `pe`=1, `vm`=1, `iopl`<3, `sw_int`=1 and `brk1`=0, the class is GP with code 0. This check comes before all other protected-mode checks. A request with `brk1`=1 skips this check.
- R5: The gate error code is vector*8+2+`ext`, with `ext` in bit 0. The class is GP with the gate error code when vector*8+7 exceeds `idt_limit`. It is also GP with that code when `gate_kind` is 00. The `gate_kind` codes are 00 invalid, 01 task, 10 interrupt and 11 trap.
- R6: When `sw_int`=1 and `gate_dpl` < `cpl`, the class is GP with the gate error code. Hardware events (`sw_int`=0) skip this check.
- R7: When `gate_present`=0, the class is NP with the gate error code. This check comes after the limit, type and privilege checks.
- R8: A present task gate (`gate_kind` 01) that passes R4 to R7 is classed task (1). No target-segment check applies to it.
- R9: For an interrupt or trap gate, a null `code_sel` (bits 15:2 all zero) gives GP with code `ext`.
- R10: The selector error code is `code_sel`[15:2] in bits 15:2, 0 in bit 1 and `ext` in bit 0. The class is GP with this code when `code_is_code`=0 or when `code_dpl` > `cpl`. After that check, `code_present`=0 gives NP with this code.
- R11: A nonconforming target with `code_dpl` < `cpl` is classed inter (3) when `vm`=0. When `vm`=1 it is classed v86 (4) if `code_dpl`=0, and GP with the selector code otherwise.
- R12: A conforming target, or one with `code_dpl` = `cpl`, is classed intra (2) when `vm`=0. When `vm`=1 the same target gives GP with the selector code.
- R13: Without a request, `out_class` and `err_code` keep their values whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Sample the inputs this cycle |
| pe | input | 1 | Protection enabled |
| vm | input | 1 | Virtual-8086 mode |
| iopl | input | 2 | I/O privilege level |
| cpl | input | 2 | Current privilege level |
| sw_int | input | 1 | Event raised by a software interrupt instruction |
| brk1 | input | 1 | Event is the one-byte breakpoint form |
| ext | input | 1 | Event is external |
| vector | input | 8 | Interrupt vector |
| idt_limit | input | 16 | Descriptor table limit in bytes |
| gate_kind | input | 2 | Gate type: 00 invalid, 01 task, 10 interrupt, 11 trap |
| gate_dpl | input | 2 | Gate privilege level |
| gate_present | input | 1 | Gate present bit |
| code_sel | input | 16 | Target code selector held in the gate |
| code_is_code | input | 1 | Target descriptor is a code segment |
| code_conf | input | 1 | Target code segment is conforming |
| code_dpl | input | 2 | Target code segment privilege level |
| code_present | input | 1 | Target code segment present bit |
| out_valid | output | 1 | Verdict valid this cycle |
| out_class | output | 3 | Dispatch or fault class |
| err_code | output | 16 | Error code for a fault, 0 for a dispatch |

## Verification
The assertions check on every cycle the properties that need no knowledge of the check order. These are the valid timing and the holding of the verdict between requests. They also cover the zero error code of every dispatch class, the I/O privilege fault that comes before everything else, and real-mode requests that never leave the real or GP classes. Only the bench's scenarios can show the full check order. Examples are a not-present gate losing to a privilege fault, a null selector checked before the code-segment checks, and the breakpoint and hardware-event exemptions. The bench's model also compares the exact error code bits for each fault source.

// File: rtl/intgate_classify.sv
module intgate_classify (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        pe,
  input  logic        vm,
  input  logic [1:0]  iopl,
  input  logic [1:0]  cpl,
  input  logic        sw_int,
  input  logic        brk1,
  input  logic        ext,
  input  logic [7:0]  vector,
  input  logic [15:0] idt_limit,
  input  logic [1:0]  gate_kind,
  input  logic [1:0]  gate_dpl,
  input  logic        gate_present,
  input  logic [15:0] code_sel,
  input  logic        code_is_code,
  input  logic        code_conf,
  input  logic [1:0]  code_dpl,
  input  logic        code_present,
  output logic        out_valid,
  output logic [2:0]  out_class,
  output logic [15:0] err_code
);

  localparam logic [2:0] C_REAL = 3'd0, C_TASK = 3'd1, C_INTRA = 3'd2,
                         C_INTER = 3'd3, C_V86 = 3'd4, C_GP = 3'd5, C_NP = 3'd6;
  localparam logic [1:0] G_BAD = 2'b00, G_TASK = 2'b01;

  logic [15:0] gate_err, sel_err, real_top, prot_top;
  logic [2:0]  cls_n;
  logic [15:0] err_n;

  assign gate_err = {5'd0, vector, 1'b0, 1'b1, ext};
  assign sel_err  = {code_sel[15:2], 1'b0, ext};
  assign real_top = {6'd0, vector, 2'b11};
  assign prot_top = {5'd0, vector, 3'b111};

  always_comb begin
    cls_n = C_GP;
    err_n = 16'd0;
    if (!pe) begin
      if (real_top <= idt_limit) cls_n = C_REAL;
    end else if (vm && iopl != 2'd3 && sw_int && !brk1) begin
      cls_n = C_GP;
    end else if (prot_top > idt_limit || gate_kind == G_BAD) begin
      err_n = gate_err;
    end else if (sw_int && gate_dpl < cpl) begin
      err_n = gate_err;
    end else if (!gate_present) begin
      cls_n = C_NP;
      err_n = gate_err;
    end else if (gate_kind == G_TASK) begin
      cls_n = C_TASK;
    end else if (code_sel[15:2] == 14'd0) begin
      err_n = {15'd0, ext};
    end else if (!code_is_code || code_dpl > cpl) begin
      err_n = sel_err;
    end else if (!code_present) begin
      cls_n = C_NP;
      err_n = sel_err;
    end else if (!code_conf && code_dpl < cpl) begin
      if (!vm)                  cls_n = C_INTER;
      else if (code_dpl == 2'd0) cls_n = C_V86;
      else                       err_n = sel_err;
    end else if (!vm) begin
      cls_n = C_INTRA;
    end else begin
      err_n = sel_err;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_class <= C_REAL;
      err_code  <= 16'd0;
    end else begin
      out_valid <= req_valid;
      if (req_valid) begin
        out_class <= cls_n;
        err_code  <= err_n;
      end
    end
  end

  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> out_valid);
  // R1
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !out_valid);
  // R2
  dispatch_zero_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_class <= C_V86) |-> err_code == 16'd0);
  // R3
  real_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !pe) |=> (out_class == C_REAL || out_class == C_GP));
  // R4
  iopl_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && pe && vm && iopl != 2'd3 && sw_int && !brk1)
      |=> (out_class == C_GP && err_code == 16'd0));
  // R11
  v86_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !vm) |=> out_class != C_V86);
  // R13
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(out_class) && $stable(err_code)));

endmodule

// File: tb/intgate_classify_test.sv
`timescale 1ns/1ps
module intgate_classify_test;
  logic clk = 0, rst_n = 0, req_valid = 0;
  logic pe, vm, sw_int, brk1, ext, gate_present, code_is_code, code_conf, code_present;
  logic [1:0] iopl, cpl, gate_kind, gate_dpl, code_dpl;
  logic [7:0] vector;
  logic [15:0] idt_limit, code_sel;
  logic out_valid;
  logic [2:0] out_class;
  logic [15:0] err_code;

  int vecs = 0, bad = 0;
  int exp_cls = 0, exp_err = 0;
  bit exp_v = 0;

  always #2.5 clk = ~clk;

  intgate_classify uut (.*);

  function automatic void model(output int c, output int e);
    int ge, se;
    ge = vector * 8 + 2 + ext;
    se = (code_sel & 16'hFFFC) + ext;
    e = 0;
    if (pe == 0) begin c = (vector * 4 + 3 > idt_limit) ? 5 : 0; return; end
    if (vm && iopl < 3 && sw_int && !brk1) begin c = 5; return; end
    if (vector * 8 + 7 > idt_limit || gate_kind == 0) begin c = 5; e = ge; return; end
    if (sw_int && gate_dpl < cpl) begin c = 5; e = ge; return; end
    if (!gate_present) begin c = 6; e = ge; return; end
    if (gate_kind == 1) begin c = 1; return; end
    if (code_sel < 4) begin c = 5; e = ext; return; end
    if (!code_is_code || code_dpl > cpl) begin c = 5; e = se; return; end
    if (!code_present) begin c = 6; e = se; return; end
    if (!code_conf && code_dpl < cpl) begin
      if (!vm) c = 3;
      else if (code_dpl == 0) c = 4;
      else begin c = 5; e = se; end
      return;
    end
    if (vm) begin c = 5; e = se; end else c = 2;
  endfunction

  task automatic check(string tag);
    vecs++;
    if (out_valid !== exp_v || (exp_v && (out_class !== exp_cls[2:0] || err_code !== exp_err[15:0]))) begin
      bad++;
      $display("FAIL %s: got v=%0b cls=%0d err=%h, want v=%0b cls=%0d err=%h",
               tag, out_valid, out_class, err_code, exp_v, exp_cls, exp_err[15:0]);
    end
  endtask

  task automatic step(bit v, string tag);
    int c, e;
    req_valid = v;
    model(c, e);
    @(negedge clk);
    exp_v = v;
    if (v) begin exp_cls = c; exp_err = e; end
    check(tag);
  endtask

  task automatic base();
    pe = 1; vm = 0; iopl = 0; cpl = 3; sw_int = 1; brk1 = 0; ext = 0;
    vector = 8'h30; idt_limit = 16'h07FF; gate_kind = 2'b10; gate_dpl = 3;
    gate_present = 1; code_sel = 16'h0008; code_is_code = 1; code_conf = 0;
    code_dpl = 0; code_present = 1;
  endtask

  initial begin
    #1_000_000;
    bad++;
    $display("FAIL watchdog: got hang, want finish");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    base();
    repeat (3) @(negedge clk);
    rst_n = 1;
    vecs++;
    if (out_valid !== 0 || out_class !== 0 || err_code !== 0) begin
      bad++; $display("FAIL R1 reset: got %0b/%0d/%h, want 0/0/0", out_valid, out_class, err_code);
    end
    step(1, "R11 inter");
    step(0, "R1 idle");
    base(); vector = 8'h99; code_sel = 16'h0000; step(0, "R13 hold");
    base(); pe = 0; vector = 8'hFF; idt_limit = 16'h03FF; step(1, "R3 real");
    idt_limit = 16'h03FE; step(1, "R3 real limit");
    base(); vm = 1; iopl = 2; step(1, "R4 iopl");
    brk1 = 1; step(1, "R4 breakpoint exempt");
    base(); vm = 1; iopl = 1; ext = 1; gate_present = 0; step(1, "R4 priority");
    base(); vector = 8'hFF; idt_limit = 16'h07FE; ext = 1; step(1, "R5 limit");
    idt_limit = 16'h07FF; step(1, "R5 limit edge");
    base(); gate_kind = 0; gate_present = 0; step(1, "R5 type");
    base(); gate_dpl = 2; gate_present = 0; step(1, "R6 dpl");
    sw_int = 0; ext = 1; step(1, "R6 hw exempt / R7 np");
    base(); gate_kind = 1; code_sel = 0; step(1, "R8 task");
    base(); code_sel = 16'h0003; ext = 1; code_is_code = 0; step(1, "R9 null");
    base(); code_sel = 16'h1237; code_is_code = 0; step(1, "R10 not code");
    code_is_code = 1; code_dpl = 0; cpl = 0; code_present = 0; step(1, "R10 np");
    base(); vm = 1; iopl = 3; step(1, "R11 v86");
    code_dpl = 1; step(1, "R11 v86 dpl");
    base(); cpl = 1; code_dpl = 1; step(1, "R12 intra");
    base(); code_conf = 1; step(1, "R12 conforming");
    vm = 1; iopl = 3; step(1, "R12 vm fault");
    base(); gate_kind = 2'b11; cpl = 0; code_dpl = 0; step(1, "R2 trap intra");
    for (int i = 0; i < 3000; i++) begin
      pe = ($urandom % 8) != 0; vm = $urandom; iopl = $urandom; cpl = $urandom;
      sw_int = $urandom; brk1 = $urandom; ext = $urandom; vector = $urandom;
      idt_limit = ($urandom % 4 == 0) ? 16'($urandom) : 16'h07FF;
      gate_kind = $urandom; gate_dpl = $urandom; gate_present = ($urandom % 6) != 0;
      code_sel = ($urandom % 8 == 0) ? 16'($urandom % 4) : 16'($urandom);
      code_is_code = ($urandom % 6) != 0; code_conf = $urandom; code_dpl = $urandom;
      code_present = ($urandom % 6) != 0;
      step(($urandom % 5) != 0, "R13 random");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule